// File: doc/BRIEF.md
# Longest-Prefix-Match Lookup Sequencer

The sequencer resolves a 32-bit IPv4 destination address to a next-hop value under the longest-prefix-match rule. With each request it receives a hit vector from a bank of per-length membership filters that cover prefix lengths 16 to 32. Those filters can report hits that are not real, so the sequencer never trusts a hit on its own. It picks the longest candidate and reads an external verification memory for it. It returns that entry only if the stored prefix and length agree with the address. A rejected candidate is dropped and the next shorter one is tried.

When no candidate survives, the sequencer reads a direct-indexed short-prefix table using the upper address bits. A zero entry in that table means there is no route. The result goes out on a valid/ready response channel and carries the next-hop, the matched length and two flags: one marks a direct-table result and one marks a miss. Only one lookup is in flight at a time, and at most one memory read is outstanding.

Top module: `lpm_lookup_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `vm_req` and `da_req` are 0.
- R2: Bit i of `req_hits` stands for prefix length 16+i. The first verification read of a lookup uses the longest length whose bit is set.
- R3: A verification read presents `vm_len` equal to the candidate length and `vm_key` equal to the address with its low 32-`vm_len` bits cleared. Read data is taken exactly RD_LAT cycles after the cycle in which `vm_req` is high.
- R4: A candidate is confirmed when the returned length equals the candidate length and the returned prefix equals the masked address. The response then carries that entry's next-hop and length, with `resp_da`=0 and `resp_miss`=0. A longer confirmed prefix wins over any shorter hit.
- R5: When a verification read disagrees, its next-hop is never returned. The next verification read uses the next shorter set bit.
- R6: When no hit bit is set, or every candidate is rejected, one direct-table read is issued with `da_idx` equal to address bits 31..17. The response then has `resp_da`=1 and `resp_len`=0.
- R7: A direct-table entry of zero gives `resp_miss`=1, `resp_da`=1 and `resp_nh`=0.
- R8: `req_ready` is 1 only when the block is idle, and a request is taken on the first rising edge where `req_valid` and `req_ready` are both 1. The response stays valid and unchanged until `resp_ready` is 1. `req_ready` is 0 while the response is held and returns to 1 in the cycle after the response handshake.
- R9: `vm_req` and `da_req` are never high together, and neither is high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block idle, request accepted this edge if valid |
| req_addr | input | 32 | Destination address |
| req_hits | input | 17 | Filter hits, bit i = prefix length 16+i |
| resp_valid | output | 1 | Result valid |
| resp_ready | input | 1 | Consumer takes the result |
| resp_nh | output | NH_W | Next-hop value |
| resp_len | output | 6 | Matched prefix length, 0 for direct-table results |
| resp_da | output | 1 | Result came from the direct-indexed table |
| resp_miss | output | 1 | No route found |
| vm_req | output | 1 | Verification memory read strobe |
| vm_len | output | 6 | Candidate length for the read |
| vm_key | output | 32 | Address masked to the candidate length |
| vm_rd_prefix | input | 32 | Stored prefix, RD_LAT cycles after the strobe |
| vm_rd_len | input | 6 | Stored prefix length |
| vm_rd_nh | input | NH_W | Stored next-hop |
| da_req | output | 1 | Direct table read strobe |
| da_idx | output | DA_W | Upper address bits used as the table index |
| da_rd_nh | input | NH_W | Direct table entry, RD_LAT cycles after the strobe |

## Verification
The response handshake and the acceptance of the next request can be offered in the same cycle. The consumer raises `resp_ready` while a producer already holds `req_valid` high with a new address. The bench arranges exactly that and confirms that `req_ready` is low in the handshake cycle and high in the next cycle. It also confirms that the second lookup then completes with its own correct result, with no trace of the first. Back-pressure is judged separately: the response is held for several cycles and must stay unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int ADDR_W   = 32;
    localparam int MIN_LEN  = 16;
    localparam int MAX_LEN  = 32;
    localparam int NUM_LEN  = MAX_LEN - MIN_LEN + 1;
    localparam int LEN_W    = $clog2(MAX_LEN + 1);
    localparam int CAND_W   = $clog2(NUM_LEN);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } lpm_state_e;

    typedef struct packed {
        logic              found;
        logic [CAND_W-1:0] idx;
    } cand_t;

    // Mask keeping the top 'len' bits of an address.
    function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        logic [ADDR_W-1:0] m;
        m = '0;
        for (int b = 0; b < ADDR_W; b++) begin
            if (b >= ADDR_W - int'(len)) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [LEN_W-1:0] idx_to_len(input logic [CAND_W-1:0] idx);
        return LEN_W'(MIN_LEN) + LEN_W'(idx);
    endfunction

endpackage

// File: rtl/lpm_cand_pick.sv
module lpm_cand_pick
    import lpm_pkg::*;
#(
    parameter int N  = NUM_LEN,
    parameter int IW = CAND_W
) (
    input  logic [N-1:0]  pend,
    output cand_t         pick,
    output logic [N-1:0]  pick_onehot
);
    logic [IW-1:0] idx;
    logic          found;

    // Highest set bit wins: later iterations overwrite earlier ones.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    assign pick.found  = found;
    assign pick.idx    = CAND_W'(idx);
    assign pick_onehot = found ? (N'(1) << idx) : '0;
endmodule

// File: rtl/lpm_entry_check.sv
module lpm_entry_check
    import lpm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  want_len,
    input  logic [ADDR_W-1:0] ent_prefix,
    input  logic [LEN_W-1:0]  ent_len,
    output logic              ok
);
    logic [ADDR_W-1:0] masked;

    assign masked = addr & len_mask(want_len);
    assign ok     = (ent_len == want_len) && (masked == ent_prefix);
endmodule

// File: rtl/lpm_wait_timer.sv
module lpm_wait_timer #(
    parameter int LAT   = 2,
    parameter int CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic done
);
    logic [CNT_W-1:0] cnt;
    logic             busy;

    assign done = busy && (cnt == CNT_W'(LAT - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (start) begin
            cnt  <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (done) busy <= 1'b0;
            else      cnt  <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/lpm_lookup_seq.sv
module lpm_lookup_seq
    import lpm_pkg::*;
#(
    parameter int NH_W   = 16,
    parameter int DA_W   = 15,
    parameter int RD_LAT = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [NUM_LEN-1:0]  req_hits,
    output logic                resp_valid,
    input  logic                resp_ready,
    output logic [NH_W-1:0]     resp_nh,
    output logic [LEN_W-1:0]    resp_len,
    output logic                resp_da,
    output logic                resp_miss,
    output logic                vm_req,
    output logic [LEN_W-1:0]    vm_len,
    output logic [ADDR_W-1:0]   vm_key,
    input  logic [ADDR_W-1:0]   vm_rd_prefix,
    input  logic [LEN_W-1:0]    vm_rd_len,
    input  logic [NH_W-1:0]     vm_rd_nh,
    output logic                da_req,
    output logic [DA_W-1:0]     da_idx,
    input  logic [NH_W-1:0]     da_rd_nh
);
    lpm_state_e           state;
    logic [ADDR_W-1:0]    addr_q;
    logic [NUM_LEN-1:0]   pend_q;
    logic [LEN_W-1:0]     cur_len_q;
    logic                 src_da_q;
    logic [NH_W-1:0]      r_nh;
    logic [LEN_W-1:0]     r_len;
    logic                 r_da;
    logic                 r_miss;

    cand_t                pick;
    logic [NUM_LEN-1:0]   pick_onehot;
    logic [LEN_W-1:0]     issue_len;
    logic                 entry_ok;
    logic                 rd_done;
    logic                 in_issue;

    lpm_cand_pick #(.N(NUM_LEN), .IW(CAND_W)) pick_i (
        .pend        (pend_q),
        .pick        (pick),
        .pick_onehot (pick_onehot)
    );

    lpm_entry_check check_i (
        .addr       (addr_q),
        .want_len   (cur_len_q),
        .ent_prefix (vm_rd_prefix),
        .ent_len    (vm_rd_len),
        .ok         (entry_ok)
    );

    lpm_wait_timer #(.LAT(RD_LAT)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .start (in_issue),
        .done  (rd_done)
    );

    assign in_issue  = (state == ST_ISSUE);
    assign issue_len = idx_to_len(pick.idx);

    assign req_ready  = (state == ST_IDLE);
    assign resp_valid = (state == ST_RESP);
    assign resp_nh    = r_nh;
    assign resp_len   = r_len;
    assign resp_da    = r_da;
    assign resp_miss  = r_miss;

    assign vm_req = in_issue && pick.found;
    assign vm_len = issue_len;
    assign vm_key = addr_q & len_mask(issue_len);
    assign da_req = in_issue && !pick.found;
    assign da_idx = addr_q[ADDR_W-1 -: DA_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            pend_q    <= '0;
            cur_len_q <= '0;
            src_da_q  <= 1'b0;
            r_nh      <= '0;
            r_len     <= '0;
            r_da      <= 1'b0;
            r_miss    <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        addr_q <= req_addr;
                        pend_q <= req_hits;
                        state  <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    if (pick.found) begin
                        cur_len_q <= issue_len;
                        pend_q    <= pend_q & ~pick_onehot;
                        src_da_q  <= 1'b0;
                    end else begin
                        src_da_q  <= 1'b1;
                    end
                    state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (rd_done) begin
                        if (src_da_q) begin
                            r_nh   <= da_rd_nh;
                            r_len  <= '0;
                            r_da   <= 1'b1;
                            r_miss <= (da_rd_nh == '0);
                            state  <= ST_RESP;
                        end else if (entry_ok) begin
                            r_nh   <= vm_rd_nh;
                            r_len  <= cur_len_q;
                            r_da   <= 1'b0;
                            r_miss <= 1'b0;
                            state  <= ST_RESP;
                        end else begin
                            state  <= ST_ISSUE;
                        end
                    end
                end
                ST_RESP: begin
                    if (resp_ready) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lpm_lookup_seq_chk.sv
module lpm_lookup_seq_chk
    import lpm_pkg::*;
#(
    parameter int NH_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_ready,
    input logic             resp_valid,
    input logic             resp_ready,
    input logic [NH_W-1:0]  resp_nh,
    input logic [LEN_W-1:0] resp_len,
    input logic             resp_da,
    input logic             resp_miss,
    input logic             vm_req,
    input logic [LEN_W-1:0] vm_len,
    input logic             da_req
);
    // R3: candidate length stays inside the filtered range
    p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
        vm_req |-> (vm_len >= LEN_W'(MIN_LEN)) && (vm_len <= LEN_W'(MAX_LEN)));

    // R6: direct-table results report length zero
    p_da_len_r6: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_da) |-> (resp_len == '0));

    // R7: miss only from the direct table, with a zero next-hop
    p_miss_r7: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_miss) |-> (resp_da && (resp_nh == '0)));

    // R8: no new request while a result is pending
    p_busy_r8: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready);

    // R8: held response is stable
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_nh)
            && $stable(resp_len) && $stable(resp_da) && $stable(resp_miss)));

    // R9: one memory read at a time
    p_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(vm_req && da_req));

    p_vm_gap_r9: assert property (@(posedge clk) disable iff (rst)
        vm_req |=> !vm_req);

    p_da_gap_r9: assert property (@(posedge clk) disable iff (rst)
        da_req |=> !da_req);
endmodule

bind lpm_lookup_seq lpm_lookup_seq_chk #(.NH_W(NH_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_ready (resp_ready),
    .resp_nh    (resp_nh),
    .resp_len   (resp_len),
    .resp_da    (resp_da),
    .resp_miss  (resp_miss),
    .vm_req     (vm_req),
    .vm_len     (vm_len),
    .da_req     (da_req)
);

// File: tb/lpm_lookup_seq_tb_top.sv
`timescale 1ns/1ps
module lpm_lookup_seq_tb_top;
    localparam int NH_W = 16;
    localparam int DA_W = 15;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [31:0]      req_addr = '0;
    logic [16:0]      req_hits = '0;
    logic             resp_valid;
    logic             resp_ready = 1'b1;
    logic [NH_W-1:0]  resp_nh;
    logic [5:0]       resp_len;
    logic             resp_da;
    logic             resp_miss;
    logic             vm_req;
    logic [5:0]       vm_len;
    logic [31:0]      vm_key;
    logic [31:0]      vm_rd_prefix = '0;
    logic [5:0]       vm_rd_len = '0;
    logic [NH_W-1:0]  vm_rd_nh = '0;
    logic             da_req;
    logic [DA_W-1:0]  da_idx;
    logic [NH_W-1:0]  da_rd_nh = '0;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    lpm_lookup_seq #(.NH_W(NH_W), .DA_W(DA_W), .RD_LAT(2)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_hits(req_hits),
        .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_nh(resp_nh), .resp_len(resp_len),
        .resp_da(resp_da), .resp_miss(resp_miss),
        .vm_req(vm_req), .vm_len(vm_len), .vm_key(vm_key),
        .vm_rd_prefix(vm_rd_prefix), .vm_rd_len(vm_rd_len), .vm_rd_nh(vm_rd_nh),
        .da_req(da_req), .da_idx(da_idx), .da_rd_nh(da_rd_nh)
    );

    // ---------------- reference data ----------------
    function automatic logic [31:0] bmask(input int l);
        logic [63:0] m;
        m = ~((64'h1 << (32 - l)) - 64'h1);
        return m[31:0];
    endfunction

    // {found, next-hop} for a stored route of length l and prefix key
    function automatic logic [16:0] route_find(input int l, input logic [31:0] key);
        if (l == 24 && key == 32'hC0A80100) return {1'b1, 16'h0024};
        if (l == 20 && key == 32'hC0A80000) return {1'b1, 16'h0020};
        if (l == 28 && key == 32'hC0A80180) return {1'b1, 16'h0028};
        if (l == 22 && key == 32'h0A000000) return {1'b1, 16'h0022};
        if (l == 32 && key == 32'hFFFFFFFF) return {1'b1, 16'h0032};
        if (l == 16 && key == 32'h8C100000) return {1'b1, 16'h0016};
        return 17'h0;
    endfunction

    function automatic logic [15:0] da_val(input logic [14:0] idx);
        if (idx[1:0] == 2'b00) return 16'h0000;
        return 16'h4000 | {1'b0, idx};
    endfunction

    function automatic logic [16:0] hb(input int l);
        return 17'h1 << (l - 16);
    endfunction

    // ---------------- memory models (2-cycle latency) ----------------
    logic        s1_v = 1'b0;
    logic [5:0]  s1_len = '0;
    logic [31:0] s1_key = '0;
    logic [14:0] s1_da = '0;

    always @(posedge clk) begin
        logic [16:0] f;
        s1_v   <= vm_req;
        s1_len <= vm_len;
        s1_key <= vm_key;
        s1_da  <= da_idx;
        f = route_find(int'(s1_len), s1_key);
        if (f[16]) begin
            vm_rd_prefix <= s1_key;
            vm_rd_nh     <= f[15:0];
        end else begin
            vm_rd_prefix <= ~s1_key;
            vm_rd_nh     <= 16'hDEAD;
        end
        vm_rd_len <= s1_len;
        da_rd_nh  <= da_val(s1_da);
    end

    // ---------------- bus monitor ----------------
    int          nlog = 0;
    int          log_len [0:63];
    logic [31:0] log_key [0:63];
    int          nda = 0;
    logic [14:0] last_da_idx = '0;
    int          overlap_err = 0;
    logic        prev_vm = 1'b0;
    logic        prev_da = 1'b0;

    always @(posedge clk) begin
        if (!rst) begin
            if (vm_req && nlog < 64) begin
                log_len[nlog] <= int'(vm_len);
                log_key[nlog] <= vm_key;
            end
            if (vm_req) nlog <= nlog + 1;
            if (da_req) begin
                nda <= nda + 1;
                last_da_idx <= da_idx;
            end
            if ((vm_req && da_req) || (vm_req && prev_vm) || (da_req && prev_da))
                overlap_err <= overlap_err + 1;
        end
        prev_vm <= vm_req;
        prev_da <= da_req;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic ref_lookup(input logic [31:0] a, input logic [16:0] h,
                              output logic [15:0] nh, output int len,
                              output bit da, output bit miss);
        logic [16:0] f;
        for (int l = 32; l >= 16; l--) begin
            if (h[l-16]) begin
                f = route_find(l, a & bmask(l));
                if (f[16]) begin
                    nh = f[15:0]; len = l; da = 0; miss = 0;
                    return;
                end
            end
        end
        nh = da_val(a[31:17]); len = 0; da = 1; miss = (nh == 16'h0);
    endtask

    logic [15:0] g_nh;
    logic [5:0]  g_len;
    logic        g_da;
    logic        g_miss;

    task automatic wait_resp(input string tag);
        int t;
        t = 0;
        while (!resp_valid && t < 300) begin
            @(negedge clk);
            t++;
        end
        chk(resp_valid, tag, "response timeout", 0, 1);
        g_nh = resp_nh; g_len = resp_len; g_da = resp_da; g_miss = resp_miss;
    endtask

    task automatic send_req(input logic [31:0] a, input logic [16:0] h);
        req_addr  = a;
        req_hits  = h;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        req_hits  = '0;
    endtask

    // full lookup plus result check against the reference
    task automatic run_and_check(input string tag, input logic [31:0] a,
                                 input logic [16:0] h);
        logic [15:0] e_nh; int e_len; bit e_da; bit e_miss;
        ref_lookup(a, h, e_nh, e_len, e_da, e_miss);
        send_req(a, h);
        wait_resp(tag);
        chk(g_nh == e_nh, tag, "next-hop", g_nh, e_nh);
        chk(int'(g_len) == e_len, tag, "length", g_len, e_len);
        chk(g_da == e_da, tag, "direct flag", g_da, e_da);
        chk(g_miss == e_miss, tag, "miss flag", g_miss, e_miss);
        @(negedge clk);
        chk(!resp_valid && req_ready, tag, "return to idle after handshake",
            {resp_valid, req_ready}, 2'b01);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
        chk(vm_req == 1'b0, "R1", "vm_req after reset", vm_req, 0);
        chk(da_req == 1'b0, "R1", "da_req after reset", da_req, 0);
    endtask

    task automatic t_single_hit();
        int s;
        s = nlog;
        run_and_check("R4", 32'hC0A80155, hb(24));
        chk(nlog - s == 1, "R3", "read count", nlog - s, 1);
        chk(log_len[s] == 24, "R3", "vm_len", log_len[s], 24);
        chk(log_key[s] == (32'hC0A80155 & bmask(24)), "R3", "vm_key masked",
            log_key[s], 32'hC0A80100);
    endtask

    task automatic t_priority();
        int s;
        s = nlog;
        run_and_check("R2", 32'hC0A80185, hb(20) | hb(24) | hb(28));
        chk(nlog - s == 1, "R2", "only longest read", nlog - s, 1);
        chk(log_len[s] == 28, "R2", "first candidate", log_len[s], 28);
    endtask

    task automatic t_false_pos();
        int s;
        s = nlog;
        run_and_check("R5", 32'h0A000311, hb(30) | hb(22));
        chk(nlog - s == 2, "R5", "retry count", nlog - s, 2);
        chk(log_len[s] == 30, "R5", "first try", log_len[s], 30);
        chk(log_len[s+1] == 22, "R5", "next shorter try", log_len[s+1], 22);
        chk(g_nh != 16'hDEAD, "R5", "rejected next-hop leaked", g_nh, 16'h0022);
    endtask

    task automatic t_bounds();
        run_and_check("R4", 32'hFFFFFFFF, hb(32) | hb(16));
        run_and_check("R4", 32'h8C10ABCD, hb(16));
    endtask

    task automatic t_fallback();
        int s; int d;
        s = nlog; d = nda;
        run_and_check("R6", 32'h12345678, hb(31) | hb(17));
        chk(nlog - s == 2, "R6", "all candidates tried", nlog - s, 2);
        chk(nda - d == 1, "R6", "one direct read", nda - d, 1);
        chk(last_da_idx == 15'(32'h12345678 >> 17), "R6", "direct index",
            last_da_idx, 32'h12345678 >> 17);
        s = nlog;
        run_and_check("R6", 32'h0A020000, '0);
        chk(nlog == s, "R6", "no verification read without hits", nlog - s, 0);
    endtask

    task automatic t_miss();
        run_and_check("R7", 32'h40000000, '0);
        chk(g_miss == 1'b1 && g_nh == 16'h0, "R7", "miss result",
            {g_miss, g_nh}, {1'b1, 16'h0});
    endtask

    task automatic t_backpressure();
        logic [15:0] h_nh;
        resp_ready = 1'b0;
        send_req(32'hC0A80155, hb(24) | hb(20));
        wait_resp("R8");
        h_nh = resp_nh;
        for (int i = 0; i < 4; i++) @(negedge clk);
        chk(resp_valid, "R8", "response held", resp_valid, 1);
        chk(resp_nh == h_nh && resp_len == 6'd24, "R8", "held value stable",
            resp_nh, h_nh);
        chk(!req_ready, "R8", "no accept while held", req_ready, 0);
        resp_ready = 1'b1;
        @(negedge clk);
        chk(!resp_valid && req_ready, "R8", "release", {resp_valid, req_ready}, 2'b01);
    endtask

    task automatic t_overlap();
        logic [15:0] e_nh; int e_len; bit e_da; bit e_miss;
        send_req(32'hC0A80185, hb(28));
        wait_resp("R8");
        chk(g_nh == 16'h0028, "R4", "first of pair", g_nh, 16'h0028);
        // offer new request in the same cycle as the response handshake
        req_addr = 32'h0A000311; req_hits = hb(22) | hb(30); req_valid = 1'b1;
        chk(!req_ready, "R8", "not ready during handshake cycle", req_ready, 0);
        @(negedge clk);
        chk(req_ready && !resp_valid, "R8", "ready one cycle later",
            {req_ready, resp_valid}, 2'b10);
        @(negedge clk);
        req_valid = 1'b0; req_hits = '0;
        chk(!req_ready, "R8", "second request taken", req_ready, 0);
        ref_lookup(32'h0A000311, hb(22) | hb(30), e_nh, e_len, e_da, e_miss);
        wait_resp("R8");
        chk(g_nh == e_nh && int'(g_len) == e_len, "R8", "second result",
            g_nh, e_nh);
        @(negedge clk);
    endtask

    // ---------------- main ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_hit();
        t_priority();
        t_false_pos();
        t_bounds();
        t_fallback();
        t_miss();
        t_backpressure();
        t_overlap();
        repeat (2) @(negedge clk);
        chk(overlap_err == 0, "R9", "read strobes overlapped or repeated", overlap_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule